// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register load or store command into a stream of single-word memory requests. A command carries a 16-bit register mask, a base address, the address of the instruction itself, the index of the base register and five control flags: index before or after the access, ascending or descending, write back the base, load or store, and use the user-mode register bank. The block accepts the command through a valid/ready pair and then offers one request per register. Each request has an address, a register index, a sequential/non-sequential tag, a user-bank flag and a store-data select with a substitute value.

Descending transfers are rewritten as ascending ones that start at the lowest address. The block then walks the mask from the lowest index upward. When the last request has been accepted, the block raises a one-cycle completion pulse. With that pulse it gives the final base value, a write-back enable and, when the status register has to be restored, a restore request. The block does not perform the restore itself. The register file and the memory sit outside the block.

Top module: `btas_seq`

## Requirements
- R1: The block issues exactly one request per set mask bit, in strictly ascending register index, and skips every clear bit.
- R2: For an ascending transfer the step between consecutive addresses is +4. The first address is base+4 with index-before (pre_idx=1) and base itself with index-after (pre_idx=0).
- R3: For a descending transfer with n set bits (up_dir=0), the sequence starts from base−4n with the before/after sense inverted. So pre_idx=1 yields base−4n … base−4 and pre_idx=0 yields base−4n+4 … base. The final base value is base−4n.
- R4: acc_seq is 0 on the first request of a command and 1 on every later request of that command.
- R5: At completion, wb_we equals wb_req AND NOT (is_load AND base register in the mask). For a non-empty ascending mask, wb_value is base+4n.
- R6: On a store, the base register's request selects acc_src=1 with acc_data equal to the original base when it is the first request. Otherwise it selects acc_src=2 with acc_data equal to the final base (base±4n). This rule takes priority over R7.
- R7: On a store, a request for register 15 that is not the base register selects acc_src=3 with acc_data equal to insn_addr+12. Every other request, and every request of a load, selects acc_src=0 with acc_data equal to 0.
- R8: An empty mask produces a single request for register 15. A load goes to base. A store goes to base−0x3C (descending, after), base−0x40 (descending, before), base (ascending, after) or base+4 (ascending, before). The final base is base±0x40.
- R9: acc_user equals user_sel AND NOT (is_load AND mask bit 15). status_restore pulses with done exactly when user_sel, is_load and mask bit 15 are all set.
- R10: start_ready is high only while no command is active. A request is held unchanged while acc_ready is low.
- R11: done is a one-cycle pulse in the cycle after the last request is accepted. wb_value holds the final base from that cycle on.
- R12: During reset start_ready is 1, and acc_valid, done, wb_we and status_restore are 0. A reset during a transfer abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Block idle, command accepted |
| reg_list | input | NREG | Register mask |
| base_addr | input | AW | Base register value |
| insn_addr | input | AW | Address of the transfer instruction |
| base_reg | input | log2(NREG) | Index of the base register |
| pre_idx | input | 1 | 1: step before access, 0: after |
| up_dir | input | 1 | 1: ascending, 0: descending |
| wb_req | input | 1 | Base write-back requested |
| is_load | input | 1 | 1: load, 0: store |
| user_sel | input | 1 | User-bank transfer requested |
| acc_valid | output | 1 | Request offered |
| acc_ready | input | 1 | Request accepted |
| acc_addr | output | AW | Request address |
| acc_reg | output | log2(NREG) | Register index of the request |
| acc_seq | output | 1 | 0: non-sequential, 1: sequential |
| acc_user | output | 1 | Use user-mode register bank |
| acc_src | output | 2 | Store data: 0 register, 1 original base, 2 final base, 3 instruction+12 |
| acc_data | output | AW | Substitute store value for acc_src≠0 |
| done | output | 1 | Completion pulse |
| wb_we | output | 1 | Write wb_value to the base register (with done) |
| wb_value | output | AW | Final base value |
| status_restore | output | 1 | Restore status from saved copy (with done) |

## Verification
The checker watches the stream on every cycle. It checks that register indices rise and that addresses step by four. It checks the non-sequential first tag and the sequential later tags, that a stalled request holds still, that a command is never accepted during a transfer, and the shape and timing of the done pulse and its companion strobes. Absolute values can only be judged by the bench's scenarios, which compare against an independent model. These cover start addresses for the four direction and index combinations, the empty-mask addresses, the base-in-list store values, the instruction+12 store, write-back suppression and the user-bank and restore decisions.

// File: rtl/btas_pkg.sv
package btas_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} btas_st_e;
  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_ORIG = 2'd1,
    SRC_END  = 2'd2,
    SRC_PC   = 2'd3
  } btas_src_e;
endpackage

// File: rtl/btas_plan.sv
module btas_plan #(
  parameter int AW     = 32,
  parameter int NREG   = 16,
  parameter int WORD_B = 4
) (
  input  logic [NREG-1:0]         reg_list,
  input  logic [AW-1:0]           base_addr,
  input  logic [$clog2(NREG)-1:0] base_reg,
  input  logic                    pre_idx,
  input  logic                    up_dir,
  input  logic                    is_load,
  input  logic                    user_sel,
  input  logic                    wb_req,
  output logic [NREG-1:0]         eff_list,
  output logic [AW-1:0]           first_addr,
  output logic [AW-1:0]           end_base,
  output logic                    user_eff,
  output logic                    psr_req,
  output logic                    wb_eff
);
  localparam int CNT_W = $clog2(NREG + 1);

  function automatic logic [CNT_W-1:0] ones(input logic [NREG-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [AW-1:0] span_bytes(input logic [CNT_W-1:0] n);
    return AW'(n) * AW'(WORD_B);
  endfunction

  logic             empty;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    span;
  logic [AW-1:0]    low;
  logic             step_first;

  always_comb begin
    empty      = (reg_list == '0);
    cnt        = empty ? CNT_W'(NREG) : ones(reg_list);
    span       = span_bytes(cnt);
    low        = up_dir ? base_addr : base_addr - span;
    step_first = up_dir ? pre_idx : !pre_idx;
    first_addr = (empty && is_load) ? base_addr
               : low + (step_first ? AW'(WORD_B) : '0);
    end_base   = up_dir ? base_addr + span : base_addr - span;
    user_eff   = user_sel && !(is_load && reg_list[NREG-1]);
    psr_req    = user_sel && is_load && reg_list[NREG-1];
    wb_eff     = wb_req && !(is_load && reg_list[base_reg]);
    eff_list   = empty ? {1'b1, {(NREG-1){1'b0}}} : reg_list;
  end
endmodule

// File: rtl/btas_pick.sv
module btas_pick #(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         mask,
  output logic [$clog2(NREG)-1:0] idx,
  output logic                    only_one
);
  localparam int IDX_W = $clog2(NREG);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
    only_one = (mask != '0) && ((mask & (mask - NREG'(1))) == '0);
  end
endmodule

// File: rtl/btas_wsel.sv
module btas_wsel #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input  logic                    is_load,
  input  logic                    first,
  input  logic [$clog2(NREG)-1:0] cur_idx,
  input  logic [$clog2(NREG)-1:0] base_reg,
  input  logic [AW-1:0]           orig_base,
  input  logic [AW-1:0]           end_base,
  input  logic [AW-1:0]           pc_val,
  output logic [1:0]              src,
  output logic [AW-1:0]           data
);
  import btas_pkg::*;
  localparam int IDX_W = $clog2(NREG);

  btas_src_e sel;

  always_comb begin
    if (is_load)                   sel = SRC_REG;
    else if (cur_idx == base_reg)  sel = first ? SRC_ORIG : SRC_END;
    else if (cur_idx == IDX_W'(NREG - 1)) sel = SRC_PC;
    else                           sel = SRC_REG;
    unique case (sel)
      SRC_ORIG: data = orig_base;
      SRC_END:  data = end_base;
      SRC_PC:   data = pc_val;
      default:  data = '0;
    endcase
    src = sel;
  end
endmodule

// File: rtl/btas_seq.sv
module btas_seq #(
  parameter int AW     = 32,
  parameter int NREG   = 16,
  parameter int WORD_B = 4,
  parameter int PC_OFS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  output logic                    start_ready,
  input  logic [NREG-1:0]         reg_list,
  input  logic [AW-1:0]           base_addr,
  input  logic [AW-1:0]           insn_addr,
  input  logic [$clog2(NREG)-1:0] base_reg,
  input  logic                    pre_idx,
  input  logic                    up_dir,
  input  logic                    wb_req,
  input  logic                    is_load,
  input  logic                    user_sel,
  output logic                    acc_valid,
  input  logic                    acc_ready,
  output logic [AW-1:0]           acc_addr,
  output logic [$clog2(NREG)-1:0] acc_reg,
  output logic                    acc_seq,
  output logic                    acc_user,
  output logic [1:0]              acc_src,
  output logic [AW-1:0]           acc_data,
  output logic                    done,
  output logic                    wb_we,
  output logic [AW-1:0]           wb_value,
  output logic                    status_restore
);
  import btas_pkg::*;
  localparam int IDX_W = $clog2(NREG);

  btas_st_e         state;
  logic [NREG-1:0]  rem;
  logic [AW-1:0]    cur_addr;
  logic             seq_q, ld_q, user_q, wbe_q, psr_q;
  logic [IDX_W-1:0] base_q;
  logic [AW-1:0]    orig_q, end_q, pc_q, wb_val_q;
  logic             done_q, wb_we_q, rst_q;

  logic [NREG-1:0]  p_list;
  logic [AW-1:0]    p_first, p_end;
  logic             p_user, p_psr, p_wb;
  logic [IDX_W-1:0] cur_idx;
  logic             only_one;

  // named events
  logic cmd_take, acc_fire, last_fire;

  btas_plan #(.AW(AW), .NREG(NREG), .WORD_B(WORD_B)) u_plan (
    .reg_list(reg_list), .base_addr(base_addr), .base_reg(base_reg),
    .pre_idx(pre_idx), .up_dir(up_dir), .is_load(is_load),
    .user_sel(user_sel), .wb_req(wb_req), .eff_list(p_list),
    .first_addr(p_first), .end_base(p_end), .user_eff(p_user),
    .psr_req(p_psr), .wb_eff(p_wb)
  );

  btas_pick #(.NREG(NREG)) u_pick (
    .mask(rem), .idx(cur_idx), .only_one(only_one)
  );

  btas_wsel #(.AW(AW), .NREG(NREG)) u_wsel (
    .is_load(ld_q), .first(!seq_q), .cur_idx(cur_idx), .base_reg(base_q),
    .orig_base(orig_q), .end_base(end_q), .pc_val(pc_q),
    .src(acc_src), .data(acc_data)
  );

  assign start_ready = (state == ST_IDLE);
  assign cmd_take    = start_valid && start_ready;
  assign acc_valid   = (state == ST_RUN);
  assign acc_fire    = acc_valid && acc_ready;
  assign last_fire   = acc_fire && only_one;

  assign acc_addr       = cur_addr;
  assign acc_reg        = cur_idx;
  assign acc_seq        = seq_q;
  assign acc_user       = user_q;
  assign done           = done_q;
  assign wb_we          = wb_we_q;
  assign wb_value       = wb_val_q;
  assign status_restore = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rem      <= '0;
      cur_addr <= '0;
      seq_q    <= 1'b0;
      ld_q     <= 1'b0;
      user_q   <= 1'b0;
      wbe_q    <= 1'b0;
      psr_q    <= 1'b0;
      base_q   <= '0;
      orig_q   <= '0;
      end_q    <= '0;
      pc_q     <= '0;
      wb_val_q <= '0;
      done_q   <= 1'b0;
      wb_we_q  <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      wb_we_q <= 1'b0;
      rst_q   <= 1'b0;
      if (cmd_take) begin
        state    <= ST_RUN;
        rem      <= p_list;
        cur_addr <= p_first;
        seq_q    <= 1'b0;
        ld_q     <= is_load;
        user_q   <= p_user;
        wbe_q    <= p_wb;
        psr_q    <= p_psr;
        base_q   <= base_reg;
        orig_q   <= base_addr;
        end_q    <= p_end;
        pc_q     <= insn_addr + AW'(PC_OFS);
      end else if (acc_fire) begin
        rem      <= rem & ~(NREG'(1) << cur_idx);
        cur_addr <= cur_addr + AW'(WORD_B);
        seq_q    <= 1'b1;
        if (last_fire) begin
          state    <= ST_IDLE;
          done_q   <= 1'b1;
          wb_we_q  <= wbe_q;
          rst_q    <= psr_q;
          wb_val_q <= end_q;
        end
      end
    end
  end
endmodule

// File: rtl/btas_chk.sv
module btas_chk #(
  parameter int AW     = 32,
  parameter int IDX_W  = 4,
  parameter int WORD_B = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_ready,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic [AW-1:0]    acc_addr,
  input logic [IDX_W-1:0] acc_reg,
  input logic             acc_seq,
  input logic             done,
  input logic             wb_we,
  input logic             status_restore
);
  p_first_nonseq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> !acc_seq);
  p_later_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (!acc_valid || acc_seq));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (!acc_valid || acc_addr == $past(acc_addr) + AW'(WORD_B)));
  p_reg_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (!acc_valid || acc_reg > $past(acc_reg)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_reg) && $stable(acc_seq)));
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !acc_valid);
  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_valid && acc_ready));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_restore_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore |-> done);
  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done);
endmodule

bind btas_seq btas_chk #(.AW(AW), .IDX_W($clog2(NREG)), .WORD_B(WORD_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ready(start_ready), .acc_valid(acc_valid),
  .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_reg(acc_reg),
  .acc_seq(acc_seq), .done(done), .wb_we(wb_we), .status_restore(status_restore)
);

// File: tb/sim_btas_seq.sv
`timescale 1ns/1ps
module sim_btas_seq;
  typedef struct packed {
    logic [15:0] lst;
    logic [31:0] base;
    logic [3:0]  breg;
    logic        pre;
    logic        up;
    logic        wb;
    logic        ld;
    logic        usr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h00F0, 32'h0000_1000, 4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h8421, 32'h0000_2000, 4'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0031, 32'h0000_3000, 4'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h00FF, 32'h0000_4000, 4'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'h8003, 32'h0000_5000, 4'd13, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{16'h0000, 32'h0000_6000, 4'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h0000, 32'h0000_6000, 4'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h0000, 32'h0000_6000, 4'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0000, 32'h0000_6000, 4'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0000, 32'h0000_7000, 4'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'hFFFF, 32'h0000_8000, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h0001, 32'h0000_0100, 4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic [31:0] insn_addr = '0;
  logic [3:0]  base_reg = '0;
  logic        pre_idx = 1'b0, up_dir = 1'b0, wb_req = 1'b0, is_load = 1'b0, user_sel = 1'b0;
  logic        acc_valid;
  logic        acc_ready = 1'b0;
  logic [31:0] acc_addr;
  logic [3:0]  acc_reg;
  logic        acc_seq, acc_user;
  logic [1:0]  acc_src;
  logic [31:0] acc_data;
  logic        done, wb_we, status_restore;
  logic [31:0] wb_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  btas_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .reg_list(reg_list), .base_addr(base_addr), .insn_addr(insn_addr),
    .base_reg(base_reg), .pre_idx(pre_idx), .up_dir(up_dir), .wb_req(wb_req),
    .is_load(is_load), .user_sel(user_sel), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_reg(acc_reg),
    .acc_seq(acc_seq), .acc_user(acc_user), .acc_src(acc_src),
    .acc_data(acc_data), .done(done), .wb_we(wb_we), .wb_value(wb_value),
    .status_restore(status_restore)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act %0d exp < 100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) if (l[i]) c++;
    return c;
  endfunction

  // model: address of the k-th request
  function automatic logic [31:0] m_addr(input vec_t v, input int k);
    int n = popc(v.lst);
    if (v.lst == 16'h0) begin
      if (v.ld) return v.base;
      if (v.up) return v.pre ? v.base + 32'd4 : v.base;
      return v.pre ? v.base - 32'h40 : v.base - 32'h3C;
    end
    if (v.up) return v.pre ? v.base + 32'(4 * (k + 1)) : v.base + 32'(4 * k);
    return v.pre ? v.base - 32'(4 * n) + 32'(4 * k)
                 : v.base - 32'(4 * n) + 32'(4 * (k + 1));
  endfunction

  function automatic logic [31:0] m_end(input vec_t v);
    int n = (v.lst == 16'h0) ? 16 : popc(v.lst);
    return v.up ? v.base + 32'(4 * n) : v.base - 32'(4 * n);
  endfunction

  task automatic run_vec(input int vi);
    vec_t v = VECS[vi];
    logic [3:0] regs [16];
    int nr = 0;
    logic [31:0] ia = 32'h0000_8000 + 32'(vi * 16);
    if (v.lst == 16'h0) begin regs[0] = 4'd15; nr = 1; end
    else for (int r = 0; r < 16; r++) if (v.lst[r]) begin regs[nr] = 4'(r); nr++; end
    @(negedge clk);
    reg_list = v.lst; base_addr = v.base; insn_addr = ia; base_reg = v.breg;
    pre_idx = v.pre; up_dir = v.up; wb_req = v.wb; is_load = v.ld; user_sel = v.usr;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(start_ready == 1'b0, "R10", "start_ready during transfer", 32'(start_ready), 32'd0);
    for (int k = 0; k < nr; k++) begin
      logic [1:0]  es;
      logic [31:0] ed;
      logic        eu;
      if (((k + vi) % 3) == 0) begin
        acc_ready = 1'b0;
        @(negedge clk);
        chk(acc_valid && acc_addr == m_addr(v, k), "R10", "held addr on stall", acc_addr, m_addr(v, k));
      end
      acc_ready = 1'b1;
      chk(acc_valid == 1'b1, "R1", "acc_valid", 32'(acc_valid), 32'd1);
      chk(acc_reg == regs[k], "R1", "register order", 32'(acc_reg), 32'(regs[k]));
      chk(acc_addr == m_addr(v, k), (v.lst == 0) ? "R8" : (v.up ? "R2" : "R3"),
          "address", acc_addr, m_addr(v, k));
      chk(acc_seq == (k != 0), "R4", "seq tag", 32'(acc_seq), 32'(k != 0));
      eu = v.usr && !(v.ld && v.lst[15]);
      chk(acc_user == eu, "R9", "user bank", 32'(acc_user), 32'(eu));
      if (v.ld) begin es = 2'd0; ed = 32'd0; end
      else if (regs[k] == v.breg) begin
        es = (k == 0) ? 2'd1 : 2'd2;
        ed = (k == 0) ? v.base : m_end(v);
      end else if (regs[k] == 4'd15) begin es = 2'd3; ed = ia + 32'd12; end
      else begin es = 2'd0; ed = 32'd0; end
      chk(acc_src == es, (es == 3) ? "R7" : "R6", "store select", 32'(acc_src), 32'(es));
      chk(acc_data == ed, (es == 3) ? "R7" : "R6", "store data", acc_data, ed);
      @(negedge clk);
    end
    acc_ready = 1'b0;
    begin
      logic ewe = v.wb && !(v.ld && v.lst[v.breg]);
      logic epr = v.usr && v.ld && v.lst[15];
      chk(done == 1'b1, "R11", "done after last", 32'(done), 32'd1);
      chk(acc_valid == 1'b0, "R11", "idle after last", 32'(acc_valid), 32'd0);
      chk(wb_we == ewe, "R5", "writeback enable", 32'(wb_we), 32'(ewe));
      chk(wb_value == m_end(v), (v.lst == 0) ? "R8" : (v.up ? "R5" : "R3"),
          "final base", wb_value, m_end(v));
      chk(status_restore == epr, "R9", "status restore", 32'(status_restore), 32'(epr));
      @(negedge clk);
      chk(done == 1'b0, "R11", "done single pulse", 32'(done), 32'd0);
      chk(wb_value == m_end(v), "R11", "final base held", wb_value, m_end(v));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(start_ready == 1'b1, "R12", "start_ready in reset", 32'(start_ready), 32'd1);
    chk(acc_valid == 1'b0, "R12", "acc_valid in reset", 32'(acc_valid), 32'd0);
    chk(done == 1'b0 && wb_we == 1'b0 && status_restore == 1'b0, "R12", "strobes in reset",
        32'({done, wb_we, status_restore}), 32'd0);
    rst_n = 1'b1;
    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // reset in the middle of a transfer
    @(negedge clk);
    reg_list = 16'h0F00; base_addr = 32'h0000_9000; up_dir = 1'b1; pre_idx = 1'b0;
    is_load = 1'b0; wb_req = 1'b1; user_sel = 1'b0; base_reg = 4'd0;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(acc_valid == 1'b1, "R12", "transfer started", 32'(acc_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk(acc_valid == 1'b0, "R12", "reset abandons transfer", 32'(acc_valid), 32'd0);
    chk(start_ready == 1'b1, "R12", "ready after reset", 32'(start_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule